// File: doc/BRIEF.md
# Comparator channel control and status

This block is the digital side of one analog comparator channel. The raw comparator decision comes in as a single asynchronous bit and passes through a two-flop synchronizer. It is then inverted when the polarity setting asks for it. It is forced low while a selected timer blanking strobe is high, and it is held low while the channel is disabled. The result is the conditioned output, which software reads as a live status bit.

A rising edge of the conditioned output sets a sticky interrupt flag. Software clears the flag by writing 1 to a separate clear register. The interrupt line is the flag gated by an interrupt enable. Two configuration registers hold the settings that go to the analog side: enable, scaler and bridge enables, hysteresis, power mode, and the input selects. Each configuration register has its own lock bit. Once software sets it, that whole register is frozen until reset.

Access is through a simple 32-bit word interface. A write happens on any clock edge where `we_i` is high. Read data is a combinational function of the address.

Top module: `cmp_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `irq_o` is 0 and every configuration output is 0.
- R2: Configuration 1 sits at offset 0x0C. Its field positions are: enable bit 0, bridge enable bit 1, scaler enable bit 2, polarity bit 3, interrupt enable bit 6, hysteresis bits 9:8, power mode bits 13:12, inverting select bits 19:16, non-inverting select bits 20 and 22, blanking source bits 27:24, lock bit 31. Unassigned bits read 0. The fields drive `en_o`, `brg_en_o`, `scl_en_o`, `hyst_o`, `pwr_o`, `inm_sel_o`, and `inp_sel_o[1]` (bit 20) and `inp_sel_o[2]` (bit 22).
- R3: Configuration 2 sits at offset 0x10. Bit 4 drives `inp_sel_o[0]` and bit 31 is its lock. All other bits read 0.
- R4: While bit 31 of configuration 1 is 1, writes to that register change none of its bits, the lock bit included. Only reset clears it.
- R5: The lock of configuration 2 freezes only configuration 2, and the lock of configuration 1 freezes only configuration 1.
- R6: Status bit 0 at offset 0x00 shows the conditioned output. A change of `cmp_raw_i` reaches it after two clock edges. With polarity set to 1 it shows the inverted decision.
- R7: Blanking source code k from 1 to 6 forces the conditioned output to 0 while `blank_i[k-1]` is 1. Code 0 and codes 7 to 15 apply no blanking.
- R8: With enable at 0, the conditioned output is 0, so the flag cannot set.
- R9: Status bit 16 is the flag. It is set on the clock edge after the conditioned output rises, it stays set, and a steady high output does not set it again once cleared.
- R10: Writing 1 to bit 16 at offset 0x04 clears the flag, and writing 0 there has no effect. When a clear and a set fall on the same edge, the flag ends up set.
- R11: `irq_o` is 1 exactly when the flag and interrupt enable (configuration 1 bit 6) are both 1.
- R12: Offset 0x04 always reads 0, and writes to offset 0x00 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | 1 | Raw comparator decision, asynchronous |
| blank_i | input | 6 | Timer blanking strobes |
| we_i | input | 1 | Write strobe |
| addr_i | input | 5 | Byte address of the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt line |
| en_o | output | 1 | Channel enable |
| brg_en_o | output | 1 | Scaler bridge enable |
| scl_en_o | output | 1 | Scaler enable |
| hyst_o | output | 2 | Hysteresis setting |
| pwr_o | output | 2 | Power mode |
| inm_sel_o | output | 4 | Inverting input select |
| inp_sel_o | output | 3 | Non-inverting input select bits |

## Verification
The hardest case to reach is a flag clear that lands on the same edge as a new rising edge of the conditioned output. The synchronizer delay makes that edge awkward to aim for with `cmp_raw_i`. The stimulus avoids the delay by using blanking, which acts without any registers. The raw input is held so that the unblanked output would be high, and the selected strobe is held high. Then, on one falling clock edge, the strobe drops and a clear write is issued together, so the rise and the clear meet on the next edge.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 5;
  localparam int NUM_BLANK = 6;
  localparam int SYNC_LEN  = 2;
  localparam int NUM_CFG   = 2;

  localparam int OFF_STAT  = 'h00;
  localparam int OFF_CLR   = 'h04;
  localparam int OFF_CFG1  = 'h0C;
  localparam int OFF_CFG2  = 'h10;

  localparam int LOCK_BIT  = 31;
  localparam int FLAG_BIT  = 16;
  localparam int CODE_W    = 4;

  localparam logic [DATA_W-1:0] CFG1_MASK = 32'h8F5F_334F;
  localparam logic [DATA_W-1:0] CFG2_MASK = 32'h8000_0010;

  typedef struct packed {
    logic              en;
    logic              brg;
    logic              scl;
    logic              pol;
    logic              iten;
    logic [1:0]        hyst;
    logic [1:0]        pwr;
    logic [3:0]        inm;
    logic [2:0]        inp;
    logic [CODE_W-1:0] blank;
  } cmp_cfg_t;

  function automatic cmp_cfg_t unpack_cfg(input logic [DATA_W-1:0] c1,
                                          input logic [DATA_W-1:0] c2);
    cmp_cfg_t r;
    r.en    = c1[0];
    r.brg   = c1[1];
    r.scl   = c1[2];
    r.pol   = c1[3];
    r.iten  = c1[6];
    r.hyst  = c1[9:8];
    r.pwr   = c1[13:12];
    r.inm   = c1[19:16];
    r.inp   = {c1[22], c1[20], c2[4]};
    r.blank = c1[27:24];
    return r;
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_lockreg.sv
module cmp_lockreg #(
  parameter int                 W     = 32,
  parameter int                 LBIT  = 31,
  parameter logic [W-1:0]       WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q <= '0;
    else if (wr_i && !q[LBIT]) q <= wdata_i & WMASK;
  end

  assign q_o = q;
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cond_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cfg1_o,
  output logic [DATA_W-1:0] cfg2_o,
  output logic              clr_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(OFF_CFG1);
  localparam logic [ADDR_W-1:0] A_CFG2 = ADDR_W'(OFF_CFG2);

  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    localparam logic [ADDR_W-1:0]  ADDR = (g == 0) ? A_CFG1 : A_CFG2;
    localparam logic [DATA_W-1:0]  MASK = (g == 0) ? CFG1_MASK : CFG2_MASK;
    cmp_lockreg #(.W(DATA_W), .LBIT(LOCK_BIT), .WMASK(MASK)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i && (addr_i == ADDR)),
      .wdata_i(wdata_i),
      .q_o    (cfg_q[g])
    );
  end

  assign cfg1_o = cfg_q[0];
  assign cfg2_o = cfg_q[1];
  assign clr_o  = we_i && (addr_i == A_CLR) && wdata_i[FLAG_BIT];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_STAT: begin
        rdata_o[0]        = cond_i;
        rdata_o[FLAG_BIT] = flag_i;
      end
      A_CFG1:  rdata_o = cfg_q[0];
      A_CFG2:  rdata_o = cfg_q[1];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmp_cond.sv
module cmp_cond
  import cmp_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 raw_s_i,
  input  logic                 en_i,
  input  logic                 pol_i,
  input  logic [CODE_W-1:0]    code_i,
  input  logic [NUM_BLANK-1:0] blank_i,
  input  logic                 clr_i,
  output logic                 cond_o,
  output logic                 flag_o
);
  logic blank_hit;
  logic cond_prev_q;
  logic flag_q;

  // codes outside 1..NUM_BLANK select nothing
  always_comb begin
    blank_hit = 1'b0;
    for (int k = 1; k <= NUM_BLANK; k++) begin
      if (code_i == CODE_W'(k)) blank_hit = blank_i[k-1];
    end
  end

  assign cond_o = en_i && (raw_s_i ^ pol_i) && !blank_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_prev_q <= 1'b0;
      flag_q      <= 1'b0;
    end else begin
      cond_prev_q <= cond_o;
      if (cond_o && !cond_prev_q) flag_q <= 1'b1;
      else if (clr_i)             flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmp_raw_i,
  input  logic [NUM_BLANK-1:0] blank_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o,
  output logic                 en_o,
  output logic                 brg_en_o,
  output logic                 scl_en_o,
  output logic [1:0]           hyst_o,
  output logic [1:0]           pwr_o,
  output logic [3:0]           inm_sel_o,
  output logic [2:0]           inp_sel_o
);
  logic              raw_s;
  logic              cond;
  logic              flag;
  logic              clr;
  logic [DATA_W-1:0] cfg1_q;
  logic [DATA_W-1:0] cfg2_q;
  cmp_cfg_t          cfg;

  cmp_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (raw_s)
  );

  cmp_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .cond_i (cond),
    .flag_i (flag),
    .rdata_o(rdata_o),
    .cfg1_o (cfg1_q),
    .cfg2_o (cfg2_q),
    .clr_o  (clr)
  );

  assign cfg = unpack_cfg(cfg1_q, cfg2_q);

  cmp_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_s_i(raw_s),
    .en_i   (cfg.en),
    .pol_i  (cfg.pol),
    .code_i (cfg.blank),
    .blank_i(blank_i),
    .clr_i  (clr),
    .cond_o (cond),
    .flag_o (flag)
  );

  assign irq_o     = flag && cfg.iten;
  assign en_o      = cfg.en;
  assign brg_en_o  = cfg.brg;
  assign scl_en_o  = cfg.scl;
  assign hyst_o    = cfg.hyst;
  assign pwr_o     = cfg.pwr;
  assign inm_sel_o = cfg.inm;
  assign inp_sel_o = cfg.inp;
endmodule

// File: rtl/cmp_ctrl_chk.sv
module cmp_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cond_i,
  input logic        flag_i,
  input logic        clr_i,
  input logic        irq_i,
  input logic [31:0] cfg1_i,
  input logic [31:0] cfg2_i
);
  assert_cfg1_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg1_i[31] |=> $stable(cfg1_i));

  assert_cfg2_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg2_i[31] |=> $stable(cfg2_i));

  assert_disabled_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg1_i[0] |-> !cond_i);

  assert_flag_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cond_i) |=> flag_i);

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !clr_i) |=> flag_i);

  assert_flag_no_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_i && !$rose(cond_i)) |=> !flag_i);

  assert_flag_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !$rose(cond_i)) |=> !flag_i);

  assert_irq_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (flag_i && cfg1_i[6]));
endmodule

bind cmp_ctrl cmp_ctrl_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cond_i(cond),
  .flag_i(flag),
  .clr_i (clr),
  .irq_i (irq_o),
  .cfg1_i(cfg1_q),
  .cfg2_i(cfg2_q)
);

// File: tb/tb_cmp_ctrl.sv
`timescale 1ns/1ps
module tb_cmp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raw = 1'b0;
  logic [5:0]  blank = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, en, brg, scl;
  logic [1:0]  hyst, pwr;
  logic [3:0]  inm;
  logic [2:0]  inp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          src;
    logic [31:0] mask;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];
  event  chk_ev;

  localparam logic [31:0] BASE = 32'h0019_3243;

  always #5 clk = ~clk;

  cmp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_raw_i(raw), .blank_i(blank),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .en_o(en), .brg_en_o(brg), .scl_en_o(scl),
    .hyst_o(hyst), .pwr_o(pwr), .inm_sel_o(inm), .inp_sel_o(inp)
  );

  // monitor: pops the expected item and compares the selected output
  initial begin
    forever begin
      item_t it;
      logic [31:0] got;
      @(chk_ev);
      #1;
      it = sb_q.pop_front();
      case (it.src)
        0:       got = rdata;
        1:       got = {31'd0, irq};
        default: got = {18'd0, en, brg, scl, hyst, pwr, inm, inp};
      endcase
      checks++;
      if ((got & it.mask) !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.req, got & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic push(input int src, input logic [31:0] mask,
                      input logic [31:0] exp, input string req);
    item_t it;
    it.src = src; it.mask = mask; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    -> chk_ev;
    #2;
  endtask

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] mask,
                        input logic [31:0] exp, input string req);
    addr = a;
    #1;
    push(0, mask, exp, req);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
  endtask

  initial begin
    cycles(2);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    chk_rd(5'h00, '1, 32'h0, "R1 status");
    chk_rd(5'h04, '1, 32'h0, "R1 clear reg");
    chk_rd(5'h0C, '1, 32'h0, "R1 cfg1");
    chk_rd(5'h10, '1, 32'h0, "R1 cfg2");
    push(1, 32'h1, 32'h0, "R1 irq");
    push(2, '1, 32'h0, "R1 cfg pins");

    // R2 fields, reserved bits dropped
    wr(5'h0C, BASE | 32'h0000_0030);
    chk_rd(5'h0C, '1, BASE, "R2 cfg1 readback");
    push(2, '1, {18'd0, 1'b1, 1'b1, 1'b0, 2'b10, 2'b11, 4'b1001, 3'b010}, "R2 cfg pins");

    // R3 cfg2 select bit
    wr(5'h10, 32'h0000_0FFF);
    chk_rd(5'h10, '1, 32'h10, "R3 cfg2 readback");
    push(2, 32'h7, 32'h3, "R3 inp_sel");

    // R6 latency, R9 flag, R11 irq
    @(negedge clk); raw = 1'b1;
    cycles(1);
    chk_rd(5'h00, 32'h1, 32'h0, "R6 one edge not yet");
    cycles(1);
    chk_rd(5'h00, 32'h1, 32'h1, "R6 after two edges");
    cycles(1);
    chk_rd(5'h00, '1, 32'h0001_0001, "R9 flag set");
    push(1, 32'h1, 32'h1, "R11 irq high");

    // R10 write 0 no effect; write 1 clears; R9 no re-set on steady high
    wr(5'h04, 32'hFFFE_FFFF);
    chk_rd(5'h00, '1, 32'h0001_0001, "R10 clear with 0");
    wr(5'h04, 32'h0001_0000);
    cycles(3);
    chk_rd(5'h00, '1, 32'h0000_0001, "R9 steady high no re-set");
    push(1, 32'h1, 32'h0, "R11 irq low after clear");

    // R12
    chk_rd(5'h04, '1, 32'h0, "R12 clear reads 0");
    wr(5'h00, 32'hFFFF_FFFF);
    chk_rd(5'h00, '1, 32'h0000_0001, "R12 status write ignored");

    // R6 polarity
    wr(5'h0C, BASE | 32'h8);
    chk_rd(5'h00, 32'h1, 32'h0, "R6 inverted high raw");
    @(negedge clk); raw = 1'b0;
    cycles(2);
    chk_rd(5'h00, 32'h1, 32'h1, "R6 inverted low raw");
    cycles(1);
    chk_rd(5'h00, 32'h0001_0000, 32'h0001_0000, "R9 flag via polarity");
    wr(5'h04, 32'h0001_0000);

    // R7 blanking selection
    wr(5'h0C, BASE | 32'h8 | (32'd3 << 24));
    @(negedge clk); blank = 6'b000100;
    chk_rd(5'h00, 32'h1, 32'h0, "R7 code 3 strobe 2 high");
    @(negedge clk); blank = 6'b111011;
    chk_rd(5'h00, 32'h1, 32'h1, "R7 code 3 other strobes");
    wr(5'h0C, BASE | 32'h8 | (32'd6 << 24));
    @(negedge clk); blank = 6'b100000;
    chk_rd(5'h00, 32'h1, 32'h0, "R7 code 6 strobe 5 high");
    wr(5'h0C, BASE | 32'h8 | (32'd9 << 24));
    @(negedge clk); blank = 6'b111111;
    chk_rd(5'h00, 32'h1, 32'h1, "R7 reserved code 9");
    wr(5'h0C, BASE | 32'h8);
    chk_rd(5'h00, 32'h1, 32'h1, "R7 code 0");

    // R10 set wins over clear on same edge
    wr(5'h0C, BASE | 32'h8 | (32'd3 << 24));
    @(negedge clk); blank = 6'b000100;
    wr(5'h04, 32'h0001_0000);
    cycles(1);
    chk_rd(5'h00, '1, 32'h0, "R10 flag cleared, blanked");
    @(negedge clk);
    blank = 6'b000000; we = 1'b1; addr = 5'h04; wdata = 32'h0001_0000;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    chk_rd(5'h00, '1, 32'h0001_0001, "R10 set wins");

    // R11 interrupt enable gating
    wr(5'h0C, (BASE | 32'h8) & ~32'h40);
    push(1, 32'h1, 32'h0, "R11 irq masked");
    chk_rd(5'h00, 32'h0001_0000, 32'h0001_0000, "R11 flag kept");
    wr(5'h0C, BASE | 32'h8);
    push(1, 32'h1, 32'h1, "R11 irq unmasked");

    // R8 disable
    wr(5'h0C, (BASE | 32'h8) & ~32'h1);
    chk_rd(5'h00, 32'h1, 32'h0, "R8 output held low");
    wr(5'h04, 32'h0001_0000);
    @(negedge clk); raw = 1'b1;
    cycles(3);
    @(negedge clk); raw = 1'b0;
    cycles(4);
    chk_rd(5'h00, '1, 32'h0, "R8 no flag while disabled");
    push(1, 32'h1, 32'h0, "R8 irq low");

    // R4 / R5 locks
    wr(5'h0C, BASE | 32'h8000_0000);
    chk_rd(5'h0C, '1, BASE | 32'h8000_0000, "R4 lock set");
    wr(5'h0C, 32'h0);
    chk_rd(5'h0C, '1, BASE | 32'h8000_0000, "R4 write ignored");
    wr(5'h10, 32'h0);
    chk_rd(5'h10, '1, 32'h0, "R5 cfg2 still writable");
    wr(5'h10, 32'h8000_0010);
    wr(5'h10, 32'h0);
    chk_rd(5'h10, '1, 32'h8000_0010, "R5 cfg2 locked");
    push(2, 32'h7, 32'h3, "R5 locked pins");
    do_reset();
    chk_rd(5'h0C, '1, 32'h0, "R4 reset unlocks cfg1");
    chk_rd(5'h10, '1, 32'h0, "R5 reset unlocks cfg2");
    wr(5'h0C, 32'h1);
    chk_rd(5'h0C, '1, 32'h1, "R4 writable after reset");

    cycles(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule